// File: doc/BRIEF.md
# Read Strobe Arrival Calibrator

This block sits beside the read capture path of a low-power DRAM interface. On a read, the first rising edge of the returned data strobe does not arrive at a fixed point. It lands two, three or four whole clock cycles after the read latency has run out, and each byte lane can land in a different cycle. The block measures that cycle per lane and then opens each lane's capture gate in the matching cycle.

Calibration starts with a pulse on `cal_start_i`. The block then issues a fixed number of training reads, one at a time. For each read it samples every lane's strobe-detect input in the three candidate cycles and records the earliest cycle that shows a hit. A lane passes when every training read reports the same earliest cycle. Its stored cycle offset is then replaced. A lane fails when any read shows no hit or reports a different cycle than the others. A failed lane raises its error bit and keeps its previous offset. Stored offsets change only when no read is in flight, so the same pulse can be used for periodic recalibration while normal traffic runs.

In normal operation every read command the controller accepts enters a latency pipe. Each lane's gate is high for the four clock cycles (eight data beats) of the burst, starting at read latency plus two plus that lane's offset code. Reads may overlap in the pipe.

Top module: `rd_strobe_cal`

## Requirements
- R1: After reset every gate, training-read, busy, done and error output is low and every lane offset code is 0.
- R2: For a read command sampled in cycle t, lane l's gate is high in exactly cycles t+RL+2+off(l) through t+RL+5+off(l) (four clocks, eight beats) and low otherwise. Here off(l) is `offset_o[2l+1:2l]`.
- R3: The gate position follows `rl_i` for any read latency from 3 to 12 clocks.
- R4: Each lane uses its own offset, so lanes with different offsets open their gates in different cycles for the same read.
- R5: An accepted calibration issues exactly TRAIN_READS one-cycle training-read pulses, all while busy. Consecutive pulses are RL+5 cycles apart.
- R6: For a training read issued in cycle t, the detect input is sampled in cycles t+RL+2, t+RL+3 and t+RL+4. The earliest cycle with a hit gives offset code 0, 1 or 2 respectively.
- R7: A lane whose detect input shows no hit in any candidate cycle of some training read gets its error bit set at completion and keeps its old offset.
- R8: A lane whose earliest hit cycle differs between training reads gets its error bit set at completion and keeps its old offset.
- R9: Offsets and error bits are updated together with a one-cycle `cal_done_o` pulse. That update happens only once no read command is left in the latency pipe.
- R10: A `cal_start_i` pulse while busy is ignored. It causes no extra training read and no extra done pulse.
- R11: An accepted `cal_start_i` clears all lane error bits in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rl_i | input | 4 | Read latency in clocks (3..12), held stable |
| rd_cmd_i | input | 1 | Normal read command accepted this cycle |
| cal_start_i | input | 1 | Start (re)calibration |
| dqs_det_i | input | 4 | Per-lane first-strobe detect |
| train_rd_o | output | 1 | Issue one training read this cycle |
| gate_o | output | 4 | Per-lane read capture gate |
| offset_o | output | 8 | Per-lane offset code, lane l at bits 2l+1:2l |
| cal_busy_o | output | 1 | Calibration in progress |
| cal_done_o | output | 1 | One-cycle pulse when results are committed |
| lane_err_o | output | 4 | Per-lane calibration failure |

## Verification
Two things can meet in the same cycle: the commit of new offsets at the end of a recalibration, and normal read bursts still travelling through the latency pipe. The bench provokes this by issuing a normal read every four cycles while a recalibration runs, and keeps that stream going well past the last training read. It judges the outcome by checking three things. No done pulse and no offset change may appear while the stream lasts. The commit must arrive only after the pipe drains. The committed codes must then match the strobe arrival the bench itself modelled.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned SLOT_MIN  = 2;
  localparam int unsigned NUM_SLOTS = 3;
  localparam int unsigned OFF_W     = 2;

  typedef enum logic [1:0] {CAL_IDLE, CAL_ISSUE, CAL_WAIT, CAL_COMMIT} cal_state_e;

  // earliest set slot wins
  function automatic logic [OFF_W-1:0] first_slot(input logic [NUM_SLOTS-1:0] hits);
    logic [OFF_W-1:0] r;
    r = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hits[s]) r = OFF_W'(s);
    end
    return r;
  endfunction
endpackage

// File: rtl/rsc_read_pipe.sv
module rsc_read_pipe #(
  parameter int unsigned DEPTH = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  output logic [DEPTH-1:0] sr_o,
  output logic             empty_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], rd_i};
  end

  assign sr_o    = sr_q;
  assign empty_o = ~|sr_q;
endmodule

// File: rtl/rsc_lane_gate.sv
module rsc_lane_gate import rsc_pkg::*; #(
  parameter int unsigned DEPTH    = 20,
  parameter int unsigned RL_W     = 4,
  parameter int unsigned GATE_CYC = 4
) (
  input  logic [DEPTH-1:0] sr_i,
  input  logic [RL_W-1:0]  rl_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             gate_o
);
  int base;

  always_comb begin
    // tap k holds a read issued k+1 cycles ago
    base   = int'(rl_i) + int'(off_i) + int'(SLOT_MIN) - 1;
    gate_o = 1'b0;
    for (int k = 0; k < int'(DEPTH); k++) begin
      if (k >= base && k < base + int'(GATE_CYC) && sr_i[k]) gate_o = 1'b1;
    end
  end
endmodule

// File: rtl/rsc_cal_fsm.sv
module rsc_cal_fsm import rsc_pkg::*; #(
  parameter int unsigned NUM_LANES   = 4,
  parameter int unsigned RL_MAX      = 12,
  parameter int unsigned RL_W        = 4,
  parameter int unsigned TRAIN_READS = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                cal_start_i,
  input  logic [RL_W-1:0]                     rl_i,
  input  logic [NUM_LANES-1:0]                dqs_det_i,
  input  logic                                pipe_empty_i,
  output logic                                train_rd_o,
  output logic                                busy_o,
  output logic                                done_o,
  output logic [NUM_LANES-1:0][OFF_W-1:0]     off_o,
  output logic [NUM_LANES-1:0]                err_o
);
  localparam int unsigned CNT_W = $clog2(RL_MAX + SLOT_MIN + NUM_SLOTS + 1);
  localparam int unsigned RD_W  = $clog2(TRAIN_READS + 1);
  localparam logic [RD_W-1:0] LAST_RD = RD_W'(TRAIN_READS - 1);

  cal_state_e                          state_q;
  logic [CNT_W-1:0]                    cnt_q;
  logic [RD_W-1:0]                     rd_num_q;
  logic [NUM_LANES-1:0][NUM_SLOTS-2:0] hit_q;
  logic [NUM_LANES-1:0][OFF_W-1:0]     ref_q, off_q;
  logic [NUM_LANES-1:0]                fail_q, err_q;
  logic                                done_q;
  logic [NUM_SLOTS-1:0]                slot_at;
  logic [NUM_LANES-1:0][NUM_SLOTS-1:0] hits_all;

  always_comb begin
    for (int s = 0; s < int'(NUM_SLOTS); s++)
      slot_at[s] = (cnt_q == CNT_W'(rl_i) + CNT_W'(int'(SLOT_MIN) + s));
    for (int l = 0; l < int'(NUM_LANES); l++)
      hits_all[l] = {dqs_det_i[l], hit_q[l]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CAL_IDLE;
      cnt_q    <= '0;
      rd_num_q <= '0;
      hit_q    <= '0;
      ref_q    <= '0;
      off_q    <= '0;
      fail_q   <= '0;
      err_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        CAL_IDLE: begin
          if (cal_start_i) begin
            state_q  <= CAL_ISSUE;
            err_q    <= '0;
            fail_q   <= '0;
            rd_num_q <= '0;
          end
        end
        CAL_ISSUE: begin
          state_q <= CAL_WAIT;
          cnt_q   <= CNT_W'(1);
          hit_q   <= '0;
        end
        CAL_WAIT: begin
          cnt_q <= cnt_q + CNT_W'(1);
          for (int l = 0; l < int'(NUM_LANES); l++)
            for (int s = 0; s < int'(NUM_SLOTS) - 1; s++)
              if (slot_at[s] && dqs_det_i[l]) hit_q[l][s] <= 1'b1;
          if (slot_at[NUM_SLOTS-1]) begin
            for (int l = 0; l < int'(NUM_LANES); l++) begin
              if (hits_all[l] == '0) fail_q[l] <= 1'b1;
              else if (rd_num_q != '0 && first_slot(hits_all[l]) != ref_q[l]) fail_q[l] <= 1'b1;
              if (rd_num_q == '0) ref_q[l] <= first_slot(hits_all[l]);
            end
            rd_num_q <= rd_num_q + RD_W'(1);
            state_q  <= (rd_num_q == LAST_RD) ? CAL_COMMIT : CAL_ISSUE;
          end
        end
        CAL_COMMIT: begin
          // no burst in flight: safe to move gates
          if (pipe_empty_i) begin
            for (int l = 0; l < int'(NUM_LANES); l++)
              if (!fail_q[l]) off_q[l] <= ref_q[l];
            err_q   <= fail_q;
            done_q  <= 1'b1;
            state_q <= CAL_IDLE;
          end
        end
        default: state_q <= CAL_IDLE;
      endcase
    end
  end

  assign train_rd_o = (state_q == CAL_ISSUE);
  assign busy_o     = (state_q != CAL_IDLE);
  assign done_o     = done_q;
  assign off_o      = off_q;
  assign err_o      = err_q;
endmodule

// File: rtl/rd_strobe_cal.sv
module rd_strobe_cal import rsc_pkg::*; #(
  parameter int unsigned NUM_LANES   = 4,
  parameter int unsigned RL_MAX      = 12,
  parameter int unsigned RL_W        = $clog2(RL_MAX + 1),
  parameter int unsigned TRAIN_READS = 4,
  parameter int unsigned BURST_LEN   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [RL_W-1:0]            rl_i,
  input  logic                       rd_cmd_i,
  input  logic                       cal_start_i,
  input  logic [NUM_LANES-1:0]       dqs_det_i,
  output logic                       train_rd_o,
  output logic [NUM_LANES-1:0]       gate_o,
  output logic [NUM_LANES*OFF_W-1:0] offset_o,
  output logic                       cal_busy_o,
  output logic                       cal_done_o,
  output logic [NUM_LANES-1:0]       lane_err_o
);
  localparam int unsigned GATE_CYC = BURST_LEN / 2;
  localparam int unsigned DEPTH    = RL_MAX + SLOT_MIN + NUM_SLOTS - 1 + GATE_CYC;

  logic [DEPTH-1:0]                sr;
  logic                            pipe_empty;
  logic [NUM_LANES-1:0][OFF_W-1:0] off_arr;

  rsc_read_pipe #(.DEPTH(DEPTH)) pipe_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_cmd_i),
    .sr_o    (sr),
    .empty_o (pipe_empty)
  );

  rsc_cal_fsm #(
    .NUM_LANES   (NUM_LANES),
    .RL_MAX      (RL_MAX),
    .RL_W        (RL_W),
    .TRAIN_READS (TRAIN_READS)
  ) fsm_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cal_start_i  (cal_start_i),
    .rl_i         (rl_i),
    .dqs_det_i    (dqs_det_i),
    .pipe_empty_i (pipe_empty),
    .train_rd_o   (train_rd_o),
    .busy_o       (cal_busy_o),
    .done_o       (cal_done_o),
    .off_o        (off_arr),
    .err_o        (lane_err_o)
  );

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    rsc_lane_gate #(.DEPTH(DEPTH), .RL_W(RL_W), .GATE_CYC(GATE_CYC)) gate_i (
      .sr_i   (sr),
      .rl_i   (rl_i),
      .off_i  (off_arr[l]),
      .gate_o (gate_o[l])
    );
    assign offset_o[l*OFF_W +: OFF_W] = off_arr[l];
  end
endmodule

// File: rtl/rd_strobe_cal_chk.sv
module rd_strobe_cal_chk #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned OFF_TOT   = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cal_start_i,
  input logic                 train_rd_o,
  input logic [NUM_LANES-1:0] gate_o,
  input logic [OFF_TOT-1:0]   offset_o,
  input logic                 cal_busy_o,
  input logic                 cal_done_o,
  input logic [NUM_LANES-1:0] lane_err_o,
  input logic                 pipe_empty_i
);
  AST_TRAIN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_rd_o |=> !train_rd_o); // R5
  AST_TRAIN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_rd_o |-> cal_busy_o); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |=> !cal_done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_done_o |-> !cal_busy_o); // R9
  AST_OFFSET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(offset_o) |-> (cal_done_o && $past(pipe_empty_i))); // R9
  AST_ERR_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lane_err_o) |-> (cal_done_o || $past(cal_start_i && !cal_busy_o))); // R7
  AST_GATE_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_empty_i |-> (gate_o == '0)); // R2
endmodule

bind rd_strobe_cal rd_strobe_cal_chk #(
  .NUM_LANES (NUM_LANES),
  .OFF_TOT   (NUM_LANES * rsc_pkg::OFF_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cal_start_i  (cal_start_i),
  .train_rd_o   (train_rd_o),
  .gate_o       (gate_o),
  .offset_o     (offset_o),
  .cal_busy_o   (cal_busy_o),
  .cal_done_o   (cal_done_o),
  .lane_err_o   (lane_err_o),
  .pipe_empty_i (pipe_empty)
);

// File: tb/rd_strobe_cal_tb_top.sv
`timescale 1ns/1ps
module rd_strobe_cal_tb_top;
  localparam int NL = 4;
  localparam int TR = 4;
  localparam int NV = 6;
  // {rl, A lane3..0, B lane3..0}; A on even training reads, B on odd; 0 = no strobe
  localparam logic [27:0] VEC [NV] = '{
    {4'd3,  3'd2,3'd4,3'd3,3'd2, 3'd2,3'd4,3'd3,3'd2},
    {4'd12, 3'd3,3'd3,3'd2,3'd4, 3'd3,3'd3,3'd2,3'd4},
    {4'd7,  3'd4,3'd3,3'd3,3'd3, 3'd4,3'd3,3'd3,3'd3},
    {4'd5,  3'd3,3'd4,3'd0,3'd2, 3'd3,3'd3,3'd0,3'd2},
    {4'd9,  3'd2,3'd2,3'd4,3'd4, 3'd2,3'd2,3'd4,3'd4},
    {4'd10, 3'd4,3'd2,3'd2,3'd3, 3'd4,3'd2,3'd3,3'd3}
  };

  logic clk = 0, rst_n = 0;
  logic [3:0] rl = 4'd3;
  logic rd_cmd = 0, cal_start = 0;
  logic [NL-1:0] dqs_det = '0;
  logic train_rd, busy, done;
  logic [NL-1:0] gate, err;
  logic [2*NL-1:0] offset;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, trd = -100, tidx = 0, last_trd = 0;
  logic [2:0] arr_a [NL], arr_b [NL];
  int exp_off [NL];
  bit finished = 0;

  always #2.5 clk = ~clk;

  rd_strobe_cal dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rl_i(rl), .rd_cmd_i(rd_cmd), .cal_start_i(cal_start),
    .dqs_det_i(dqs_det), .train_rd_o(train_rd), .gate_o(gate), .offset_o(offset),
    .cal_busy_o(busy), .cal_done_o(done), .lane_err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // strobe model and training-read spacing monitor
  initial forever begin
    @(negedge clk);
    cyc++;
    if (train_rd) begin
      if (tidx > 0) chk("R5 training read spacing", cyc - last_trd, rl + 5);
      last_trd = cyc;
      trd = cyc;
      tidx++;
    end
    for (int l = 0; l < NL; l++) begin
      int a;
      a = ((tidx - 1) % 2 == 0) ? int'(arr_a[l]) : int'(arr_b[l]);
      dqs_det[l] = (a != 0) && (cyc >= trd + rl + a) && (cyc < trd + rl + a + 4);
    end
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic run_cal(input logic [27:0] v, input int idx);
    bit seen;
    rl = v[27:24];
    for (int l = 0; l < NL; l++) begin
      arr_a[l] = v[12 + 3*l +: 3];
      arr_b[l] = v[3*l +: 3];
    end
    tidx = 0;
    @(negedge clk); cal_start = 1;
    @(negedge clk); cal_start = 0;
    chk($sformatf("R11 errors cleared v%0d", idx), 32'(err), 0);
    wait_done(seen);
    chk($sformatf("R9 done seen v%0d", idx), 32'(seen), 1);
    chk($sformatf("R5 training read count v%0d", idx), tidx, TR);
    for (int l = 0; l < NL; l++) begin
      bit bad;
      bad = (arr_a[l] == 0) || (arr_a[l] != arr_b[l]);
      if (!bad) exp_off[l] = int'(arr_a[l]) - 2;
      chk($sformatf("R6 R7 R8 lane%0d error v%0d", l, idx), 32'(err[l]), 32'(bad));
      chk($sformatf("R6 lane%0d offset v%0d", l, idx), 32'(offset[2*l +: 2]), exp_off[l]);
    end
  endtask

  task automatic check_gate(input int idx);
    logic [31:0] seen_m [NL];
    for (int l = 0; l < NL; l++) seen_m[l] = '0;
    @(negedge clk); rd_cmd = 1;
    for (int n = 1; n < 30; n++) begin
      @(negedge clk); rd_cmd = 0;
      for (int l = 0; l < NL; l++) if (gate[l]) seen_m[l][n] = 1'b1;
    end
    for (int l = 0; l < NL; l++) begin
      logic [31:0] e;
      e = '0;
      for (int n = 0; n < 4; n++) e[rl + 2 + exp_off[l] + n] = 1'b1;
      chk($sformatf("R2 R3 R4 lane%0d gate window v%0d", l, idx), seen_m[l], e);
    end
  endtask

  initial begin
    bit seen;
    int dones;
    for (int l = 0; l < NL; l++) begin arr_a[l] = 0; arr_b[l] = 0; exp_off[l] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", 32'(gate), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 offsets", 32'(offset), 0);
    chk("R1 errors", 32'(err), 0);
    chk("R1 busy/done/train", {29'd0, busy, done, train_rd}, 0);
    check_gate(-1);

    for (int v = 0; v < NV; v++) begin
      run_cal(VEC[v], v);
      check_gate(v);
    end

    // R10: second start while busy is ignored
    rl = 4'd6;
    for (int l = 0; l < NL; l++) begin arr_a[l] = 3'd3; arr_b[l] = 3'd3; end
    tidx = 0; dones = 0;
    @(negedge clk); cal_start = 1;
    @(negedge clk); cal_start = 0;
    repeat (8) @(negedge clk);
    cal_start = 1;
    @(negedge clk); cal_start = 0;
    for (int i = 0; i < 150; i++) begin @(negedge clk); if (done) dones++; end
    chk("R10 single done", dones, 1);
    chk("R10 training reads", tidx, TR);
    for (int l = 0; l < NL; l++) exp_off[l] = 1;
    chk("R10 offsets", 32'(offset), 32'h55);

    // R9: commit waits while reads stream through the pipe
    rl = 4'd4;
    for (int l = 0; l < NL; l++) begin arr_a[l] = 3'd4; arr_b[l] = 3'd4; end
    tidx = 0; seen = 0;
    @(negedge clk); cal_start = 1;
    @(negedge clk); cal_start = 0;
    for (int i = 0; i < 100; i++) begin
      rd_cmd = (i % 4 == 0);
      @(negedge clk);
      if (done) seen = 1;
    end
    rd_cmd = 0;
    chk("R9 no commit during reads", 32'(seen), 0);
    chk("R9 offsets held during reads", 32'(offset), 32'h55);
    wait_done(seen);
    chk("R9 commit after drain", 32'(seen), 1);
    chk("R9 new offsets", 32'(offset), 32'haa);
    for (int l = 0; l < NL; l++) exp_off[l] = 2;
    check_gate(99);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule